// File: doc/BRIEF.md
# ECC Error Event Reporting Unit

This unit collects error events from a set of memory channels whose ECC checkers run elsewhere. Each channel raises two kinds of strobe: one when a single-bit error was corrected on the fly, and one when an error could not be corrected. Both strobes carry the address of the faulting access. For each channel and each event class the unit keeps a sticky flag and a captured address. It can also drive one interrupt line per channel, with a separate enable for each event class.

Software reaches the unit through a plain 32-bit register bus. Each request presents its privilege level and transfer size alongside the address. Only full-word accesses made in supervisor mode are carried out. Any other access completes with an error response and leaves every register untouched. Each request gets its response one clock later.

Top module: `ecc_rpt`

## Requirements
- R1: After reset the configuration word, the status word and every captured address read as zero, and all `irq` lines are low.
- R2: A corrected-event strobe on channel c sets status bit 2c and captures its address into the word at byte offset 0x20 + 8c.
- R3: A non-correctable strobe on channel c sets status bit 2c+1 and captures its address into the word at byte offset 0x24 + 8c.
- R4: While a flag is set, a new event of the same class and channel leaves the captured address unchanged and the flag set.
- R5: The status word at offset 0x10 is write-1-to-clear. Writing a 0 to a bit leaves it as it is. After a flag has been cleared, the next event of that class captures its address again.
- R6: If an event arrives in the same cycle as a write-1-to-clear of its flag, the event wins: the flag stays set and the new address is captured.
- R7: Configuration bit 2c enables the corrected-event interrupt of channel c, and bit 2c+1 enables its non-correctable interrupt. `irq[c]` is high exactly while some flag of channel c is set and also enabled.
- R8: The configuration word at offset 0x00 is read/write. Bits at positions 2*NCH and above read as zero.
- R9: A request with `req_priv` low (user mode) gets `rsp_err` high and read data of zero, and changes no register.
- R10: A request whose `req_size` is not the word code (0 = byte, 1 = halfword, 2 = word) gets `rsp_err` high and read data of zero, and changes no register.
- R11: A legal access to any offset that is not mapped, including an offset that is not word aligned, reads zero with `rsp_err` low, and a write to it changes nothing.
- R12: `rsp_valid` is high in the cycle after a request and low in the cycle after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = supervisor, 0 = user |
| req_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word |
| req_addr | input | OW | Byte offset within the unit |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Error termination |
| rsp_rdata | output | 32 | Read data |
| ce_valid | input | NCH | Corrected-event strobe, one per channel |
| ce_addr | input | NCH*AW | Corrected-event address, channel c in bits c*AW upward |
| ue_valid | input | NCH | Non-correctable event strobe, one per channel |
| ue_addr | input | NCH*AW | Non-correctable event address, channel c in bits c*AW upward |
| irq | output | NCH | Interrupt per channel |

## Verification
The capture path is driven in four ways: a lone event into an empty slot, a repeated event into an occupied slot, an event after the flag has been cleared, and an event landing in the same cycle as the clear. Together these show whether the block fills the slot, holds it, frees it, and gives the event priority over the clear. The bus side is tried with user-mode, byte and halfword requests, with legal words to mapped and unmapped offsets, and with reads made after each of them. This separates a request that is refused from one that is merely ignored. The interrupt lines are checked under several enable masks with flags present on both channels, which shows that each class is gated separately.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam int OFS_CFG   = 'h00;
    localparam int OFS_STAT  = 'h10;
    localparam int OFS_ABASE = 'h20;
    localparam int OFS_STEP  = 8;
endpackage

// File: rtl/ecc_rpt_chan.sv
module ecc_rpt_chan #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_valid,
    input  logic [AW-1:0] ce_addr,
    input  logic          ue_valid,
    input  logic [AW-1:0] ue_addr,
    input  logic          clr_ce,
    input  logic          clr_ue,
    input  logic          en_ce,
    input  logic          en_ue,
    output logic          ce_flag,
    output logic          ue_flag,
    output logic [AW-1:0] ce_cap,
    output logic [AW-1:0] ue_cap,
    output logic          irq
);
    typedef struct packed {
        logic          ce_flag;
        logic          ue_flag;
        logic [AW-1:0] ce_cap;
        logic [AW-1:0] ue_cap;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_ce) st_d.ce_flag = 1'b0;
        if (clr_ue) st_d.ue_flag = 1'b0;
        // a slot accepts a new event when empty or being freed this cycle
        if (ce_valid && (!st_q.ce_flag || clr_ce)) begin
            st_d.ce_flag = 1'b1;
            st_d.ce_cap  = ce_addr;
        end
        if (ue_valid && (!st_q.ue_flag || clr_ue)) begin
            st_d.ue_flag = 1'b1;
            st_d.ue_cap  = ue_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ce_flag = st_q.ce_flag;
    assign ue_flag = st_q.ue_flag;
    assign ce_cap  = st_q.ce_cap;
    assign ue_cap  = st_q.ue_cap;
    assign irq     = (st_q.ce_flag & en_ce) | (st_q.ue_flag & en_ue);
endmodule

// File: rtl/ecc_rpt_regs.sv
module ecc_rpt_regs
    import ecc_rpt_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 32,
    parameter int OW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic [1:0]        req_size,
    input  logic [OW-1:0]     req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [NCH-1:0]    ce_flag,
    input  logic [NCH-1:0]    ue_flag,
    input  logic [NCH*AW-1:0] ce_cap,
    input  logic [NCH*AW-1:0] ue_cap,
    output logic [2*NCH-1:0]  cfg,
    output logic [NCH-1:0]    clr_ce,
    output logic [NCH-1:0]    clr_ue,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata
);
    localparam int CFGW = 2 * NCH;

    typedef struct packed {
        logic [CFGW-1:0] cfg;
        logic            rsp_valid;
        logic            rsp_err;
        logic [31:0]     rsp_rdata;
    } regs_st_t;

    regs_st_t st_d, st_q;
    logic        legal, wr_ok, rd_ok;
    logic        hit_stat;
    logic [31:0] rd_word;
    logic        unused_wdata;

    assign unused_wdata = ^req_wdata[31:CFGW];
    assign legal    = req_priv && (req_size == SZ_WORD);
    assign wr_ok    = req_valid && legal && req_write;
    assign rd_ok    = req_valid && legal && !req_write;
    assign hit_stat = (req_addr == OW'(OFS_STAT));

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            clr_ce[c] = wr_ok && hit_stat && req_wdata[2*c];
            clr_ue[c] = wr_ok && hit_stat && req_wdata[2*c+1];
        end
    end

    always_comb begin
        rd_word = '0;
        if (req_addr == OW'(OFS_CFG)) rd_word = 32'(st_q.cfg);
        if (hit_stat) begin
            for (int c = 0; c < NCH; c++) begin
                rd_word[2*c]   = ce_flag[c];
                rd_word[2*c+1] = ue_flag[c];
            end
        end
        for (int c = 0; c < NCH; c++) begin
            if (req_addr == OW'(OFS_ABASE + OFS_STEP*c))
                rd_word = 32'(ce_cap[c*AW +: AW]);
            if (req_addr == OW'(OFS_ABASE + OFS_STEP*c + 4))
                rd_word = 32'(ue_cap[c*AW +: AW]);
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_ok && req_addr == OW'(OFS_CFG)) st_d.cfg = req_wdata[CFGW-1:0];
        st_d.rsp_valid = req_valid;
        st_d.rsp_err   = req_valid && !legal;
        st_d.rsp_rdata = rd_ok ? rd_word : 32'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg       = st_q.cfg;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_rdata = st_q.rsp_rdata;
endmodule

// File: rtl/ecc_rpt.sv
module ecc_rpt #(
    parameter int NCH = 2,
    parameter int AW  = 32,
    parameter int OW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic [1:0]        req_size,
    input  logic [OW-1:0]     req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    input  logic [NCH-1:0]    ce_valid,
    input  logic [NCH*AW-1:0] ce_addr,
    input  logic [NCH-1:0]    ue_valid,
    input  logic [NCH*AW-1:0] ue_addr,
    output logic [NCH-1:0]    irq
);
    logic [2*NCH-1:0]  cfg;
    logic [NCH-1:0]    clr_ce, clr_ue, ce_flag, ue_flag;
    logic [NCH*AW-1:0] ce_cap, ue_cap;

    ecc_rpt_regs #(.NCH(NCH), .AW(AW), .OW(OW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_priv(req_priv),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .ce_flag(ce_flag), .ue_flag(ue_flag), .ce_cap(ce_cap), .ue_cap(ue_cap),
        .cfg(cfg), .clr_ce(clr_ce), .clr_ue(clr_ue),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        ecc_rpt_chan #(.AW(AW)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .ce_valid(ce_valid[g]), .ce_addr(ce_addr[g*AW +: AW]),
            .ue_valid(ue_valid[g]), .ue_addr(ue_addr[g*AW +: AW]),
            .clr_ce(clr_ce[g]), .clr_ue(clr_ue[g]),
            .en_ce(cfg[2*g]), .en_ue(cfg[2*g+1]),
            .ce_flag(ce_flag[g]), .ue_flag(ue_flag[g]),
            .ce_cap(ce_cap[g*AW +: AW]), .ue_cap(ue_cap[g*AW +: AW]),
            .irq(irq[g])
        );
    end
endmodule

// File: rtl/ecc_rpt_chk.sv
module ecc_rpt_chk #(
    parameter int NCH = 2,
    parameter int AW  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_priv,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [31:0]       rsp_rdata,
    input logic [NCH-1:0]    ce_valid,
    input logic [NCH-1:0]    ue_valid,
    input logic [NCH-1:0]    irq,
    input logic [2*NCH-1:0]  cfg,
    input logic [NCH-1:0]    ce_flag,
    input logic [NCH-1:0]    ue_flag,
    input logic [NCH*AW-1:0] ce_cap,
    input logic [NCH*AW-1:0] ue_cap,
    input logic [NCH-1:0]    clr_ce,
    input logic [NCH-1:0]    clr_ue
);
    // R12
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R12
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R9
    user_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_priv) |=> rsp_err);
    // R10
    size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != 2'd2) |=> rsp_err);
    // R9
    illegal_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (!req_priv || req_size != 2'd2)) |=> $stable(cfg));
    // R10
    err_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'd0));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // R2
        ce_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ce_valid[g] |=> ce_flag[g]);
        // R3
        ue_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ue_valid[g] |=> ue_flag[g]);
        // R4
        ce_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ce_flag[g] && !clr_ce[g]) |=> (ce_flag[g] && $stable(ce_cap[g*AW +: AW])));
        // R4
        ue_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ue_flag[g] && !clr_ue[g]) |=> (ue_flag[g] && $stable(ue_cap[g*AW +: AW])));
        // R7
        irq_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ce_flag[g] && cfg[2*g]) |-> irq[g]);
        // R7
        irq_ue_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ue_flag[g] && cfg[2*g+1]) |-> irq[g]);
        // R7
        irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> (ce_flag[g] || ue_flag[g]));
    end
endmodule

bind ecc_rpt ecc_rpt_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
    .req_size(req_size), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .ce_valid(ce_valid), .ue_valid(ue_valid),
    .irq(irq), .cfg(cfg), .ce_flag(ce_flag), .ue_flag(ue_flag),
    .ce_cap(ce_cap), .ue_cap(ue_cap), .clr_ce(clr_ce), .clr_ue(clr_ue)
);

// File: tb/ecc_rpt_bench.sv
module ecc_rpt_bench;
    localparam int NCH = 2;
    localparam int AW  = 32;
    localparam int OW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
    logic [1:0]        req_size = 2'd0;
    logic [OW-1:0]     req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [31:0]       rsp_rdata;
    logic [NCH-1:0]    ce_valid = '0, ue_valid = '0;
    logic [NCH*AW-1:0] ce_addr = '0, ue_addr = '0;
    logic [NCH-1:0]    irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ecc_rpt #(.NCH(NCH), .AW(AW), .OW(OW)) u_ecc_rpt (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_priv(req_priv), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .ce_valid(ce_valid), .ce_addr(ce_addr),
        .ue_valid(ue_valid), .ue_addr(ue_addr), .irq(irq)
    );

    typedef struct packed {
        logic        priv;
        logic [1:0]  sz;
        logic        wr;
        logic [7:0]  a;
        logic [31:0] wd;
        logic        err;
        logic [31:0] rd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd2, 1'b1, 8'h00, 32'h0000_000F, 1'b1, 32'h0, 8'd9},  // R9 user write
        '{1'b1, 2'd2, 1'b0, 8'h00, 32'h0,         1'b0, 32'h0, 8'd9},  // R9 cfg untouched
        '{1'b1, 2'd0, 1'b1, 8'h00, 32'h0000_000F, 1'b1, 32'h0, 8'd10}, // R10 byte write
        '{1'b1, 2'd1, 1'b0, 8'h10, 32'h0,         1'b1, 32'h0, 8'd10}, // R10 halfword read
        '{1'b1, 2'd2, 1'b0, 8'h00, 32'h0,         1'b0, 32'h0, 8'd10}, // R10 cfg untouched
        '{1'b1, 2'd2, 1'b1, 8'h00, 32'hFFFF_FFFF, 1'b0, 32'h0, 8'd8},  // R8 write all ones
        '{1'b1, 2'd2, 1'b0, 8'h00, 32'h0,         1'b0, 32'hF, 8'd8},  // R8 upper bits zero
        '{1'b1, 2'd2, 1'b0, 8'h10, 32'h0,         1'b0, 32'h1, 8'd2},  // R2 status bit 0
        '{1'b1, 2'd2, 1'b0, 8'h20, 32'h0,         1'b0, 32'h1000_00A4, 8'd2}, // R2 address
        '{1'b1, 2'd2, 1'b0, 8'h24, 32'h0,         1'b0, 32'h0, 8'd3},  // R3 slot still empty
        '{1'b0, 2'd2, 1'b1, 8'h10, 32'h0000_0001, 1'b1, 32'h0, 8'd9},  // R9 user clear
        '{1'b1, 2'd2, 1'b0, 8'h10, 32'h0,         1'b0, 32'h1, 8'd9},  // R9 flag kept
        '{1'b1, 2'd2, 1'b1, 8'h14, 32'hFFFF_FFFF, 1'b0, 32'h0, 8'd11}, // R11 reserved write
        '{1'b1, 2'd2, 1'b0, 8'h14, 32'h0,         1'b0, 32'h0, 8'd11}, // R11 reserved read
        '{1'b1, 2'd2, 1'b0, 8'h00, 32'h0,         1'b0, 32'hF, 8'd11}, // R11 cfg unchanged
        '{1'b1, 2'd2, 1'b0, 8'h21, 32'h0,         1'b0, 32'h0, 8'd11}, // R11 misaligned
        '{1'b1, 2'd2, 1'b1, 8'h00, 32'h0,         1'b0, 32'h0, 8'd8},  // R8 write zero
        '{1'b1, 2'd2, 1'b0, 8'h00, 32'h0,         1'b0, 32'h0, 8'd8}   // R8 read back
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // starts and ends at a falling edge; response sampled one edge later
    task automatic xfer(input logic p, input logic [1:0] s, input logic w,
                        input logic [7:0] a, input logic [31:0] wd,
                        output logic err, output logic [31:0] rd, output logic vld);
        req_valid = 1'b1; req_priv = p; req_size = s; req_write = w;
        req_addr = a; req_wdata = wd;
        @(negedge clk);
        err = rsp_err; rd = rsp_rdata; vld = rsp_valid;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic e, v; logic [31:0] d;
        xfer(1'b1, 2'd2, 1'b0, a, 32'h0, e, d, v);
        check(!e && v && d == exp, req, $sformatf("read %h", a), d, exp);
    endtask

    task automatic wr_ok(input logic [7:0] a, input logic [31:0] wd, input string req);
        logic e, v; logic [31:0] d;
        xfer(1'b1, 2'd2, 1'b1, a, wd, e, d, v);
        check(!e && v, req, $sformatf("write %h", a), {31'd0, e}, 32'd0);
    endtask

    task automatic event_in(input bit ue, input int ch, input logic [31:0] a);
        if (ue) begin ue_valid[ch] = 1'b1; ue_addr[ch*AW +: AW] = a; end
        else    begin ce_valid[ch] = 1'b1; ce_addr[ch*AW +: AW] = a; end
        @(negedge clk);
        ce_valid = '0; ue_valid = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic e, v; logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(irq == '0, "R1", "irq after reset", 32'(irq), 32'd0);
        check(!rsp_valid, "R12", "no response when idle", {31'd0, rsp_valid}, 32'd0);
        rd_chk(8'h00, 32'h0, "R1");
        rd_chk(8'h10, 32'h0, "R1");
        rd_chk(8'h20, 32'h0, "R1");
        rd_chk(8'h2C, 32'h0, "R1");

        event_in(1'b0, 0, 32'h1000_00A4);  // R2 setup
        for (int i = 0; i < NV; i++) begin
            xfer(TBL[i].priv, TBL[i].sz, TBL[i].wr, TBL[i].a, TBL[i].wd, e, d, v);
            check(v && e == TBL[i].err, $sformatf("R%0d", TBL[i].req),
                  $sformatf("row %0d err", i), {31'd0, e}, {31'd0, TBL[i].err});
            check(d == TBL[i].rd, $sformatf("R%0d", TBL[i].req),
                  $sformatf("row %0d data", i), d, TBL[i].rd);
        end

        // R3 non-correctable on channel 1
        event_in(1'b1, 1, 32'hDEAD_0010);
        rd_chk(8'h10, 32'h9, "R3");
        rd_chk(8'h2C, 32'hDEAD_0010, "R3");
        // R4 second corrected event on channel 0 keeps the old address
        event_in(1'b0, 0, 32'h0000_2222);
        rd_chk(8'h20, 32'h1000_00A4, "R4");
        rd_chk(8'h10, 32'h9, "R4");
        // R7 interrupt gating
        check(irq == 2'b00, "R7", "irq all disabled", 32'(irq), 32'd0);
        wr_ok(8'h00, 32'h8, "R7");
        check(irq == 2'b10, "R7", "irq ch1 ue enabled", 32'(irq), 32'd2);
        wr_ok(8'h00, 32'h4, "R7");
        check(irq == 2'b00, "R7", "irq ch1 ce enable only", 32'(irq), 32'd0);
        wr_ok(8'h00, 32'h9, "R7");
        check(irq == 2'b11, "R7", "irq both", 32'(irq), 32'd3);
        // R5 write-1-to-clear
        wr_ok(8'h10, 32'h8, "R5");
        check(irq == 2'b01, "R5", "irq after clearing ch1", 32'(irq), 32'd1);
        rd_chk(8'h10, 32'h1, "R5");
        wr_ok(8'h10, 32'h0, "R5");
        rd_chk(8'h10, 32'h1, "R5");
        wr_ok(8'h10, 32'h1, "R5");
        rd_chk(8'h10, 32'h0, "R5");
        check(irq == 2'b00, "R7", "irq after all cleared", 32'(irq), 32'd0);
        event_in(1'b0, 0, 32'h0000_3333);
        rd_chk(8'h20, 32'h0000_3333, "R5");
        // R6 event and clear in the same cycle
        ce_valid[0] = 1'b1; ce_addr[0 +: AW] = 32'h0000_4444;
        xfer(1'b1, 2'd2, 1'b1, 8'h10, 32'h1, e, d, v);
        ce_valid = '0;
        check(!e, "R6", "clear accepted", {31'd0, e}, 32'd0);
        rd_chk(8'h10, 32'h1, "R6");
        rd_chk(8'h20, 32'h0000_4444, "R6");
        // R12 idle cycle gives no response
        @(negedge clk);
        check(!rsp_valid, "R12", "idle response", {31'd0, rsp_valid}, 32'd0);
        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check(irq == '0, "R1", "irq in reset", 32'(irq), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(8'h00, 32'h0, "R1");
        rd_chk(8'h10, 32'h0, "R1");
        rd_chk(8'h20, 32'h0, "R1");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule